// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a full-duplex SPI master that moves 8-bit words. Software reaches it through a small word-addressed register port. The port holds a control/status word, a data port into a pair of 16-entry byte FIFOs, a clock divider and a length word. The serial clock is made from the system clock as a divided enable, so the whole block runs in one clock domain.

Software loads bytes into the transmit FIFO and sets the transfer-active bit. The block then shifts each byte out MSB first on the data-out pin. For every byte sent, one received byte is pushed into the receive FIFO. An idle serial-clock period follows every byte. Three chip-select lines are decoded from a 2-bit field. Each line has its own polarity and all of them are gated by a global enable-polarity bit. In three-wire mode the data pin driver is released and received bits are taken from the shared pin. A single interrupt output combines "transfer finished" with "receive FIFO needs service".

Top module: `spi_reg_master`

## Requirements
- R1: Registers are decoded on bus_addr[3:2]. Control/status is at 0x0, the data FIFO at 0x4, the divider at 0x8 and the length word at 0xC. After reset the control/status word reads 0x0004_0000, with only the TX-space flag set. The divider and length read 0, irq_o is 0 and every chip-select line sits at its inactive level.
- R2: The divider value D has its bit 0 ignored. The serial clock period is D rounded down to even system cycles. A rounded value of 0 gives a period of 65536 cycles.
- R3: Each byte takes 9 serial-clock periods: 8 data periods, then one period held at the idle level (CPOL). Within a byte, rising edges are one period apart. Across a byte boundary they are two periods apart.
- R4: Each transmitted byte goes out MSB first on mosi_o and pushes exactly one received byte into the RX FIFO. CPOL (bit 3) sets the idle level. CPHA (bit 2) selects sampling on the leading edge (0) or the trailing edge (1).
- R5: DONE (status bit 16) is TA (bit 7) AND TX FIFO empty AND shifter idle. Setting TA with an empty TX FIFO raises DONE on the next cycle, and raises irq_o when interrupt-on-done (bit 9) is set.
- R6: Writing 1 to bit 4 empties the TX FIFO and writing 1 to bit 5 empties the RX FIFO. Both bits read back 0.
- R7: Bits [1:0] select chip-select line 0, 1 or 2; the value 3 selects none. Line i is at its active level only while (TA or shifting) and bit 6 is 1. The active level of line i is control bit 21+i, and its inactive level is the complement of that bit.
- R8: With read-enable (bit 12) set, mosi_oe is 0 and received bits come from dq_i instead of miso_i.
- R9: Status flags: bit 17 means the RX FIFO is not empty, bit 18 means the TX FIFO is not full, bit 19 means the RX FIFO holds at least 12 bytes, and bit 20 means the RX FIFO is full. With bit 10 set, irq_o follows bit 19.
- R10: A data write to a full 16-byte TX FIFO is dropped. A data read from an empty RX FIFO pops nothing and disturbs no pointer.
- R11: Clearing TA mid-byte lets the current byte finish, including its receive push. No further byte starts, and the chip select is released once the shifter is idle.
- R12: The length register stores and returns 16 bits. Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Data pin output enable |
| miso_i | input | 1 | Serial data in (four-wire) |
| dq_i | input | 1 | Shared data pin input (three-wire) |
| cs_o | output | 3 | Chip-select lines |
| irq_o | output | 1 | Interrupt |

## Verification
The bench loops the data line back inverted on miso_i and straight on dq_i. A design that reads the wrong pin in three-wire mode, or sends LSB first, returns a byte that is visibly wrong for each CPOL/CPHA pair. It measures serial-clock edge spacing with an odd divider and across a byte boundary, which catches a missing idle clock or an unrounded divisor. It also checks the 65536-cycle period for a zero divider. It fills both FIFOs to the brim to show a seventeenth byte being dropped and the receive thresholds switching at exactly 12 and 16 entries. It drops TA mid-byte, where a faulty design would either cut the byte short or carry on into the next one.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        miso_i,
  input  logic        dq_i,
  output logic [2:0]  cs_o,
  output logic        irq_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] RXR_LVL = (AW+1)'((DEPTH * 3) / 4);

  logic [1:0]  csel;
  logic        cpha, cpol, gpol, ta, intd, intr, ren;
  logic [2:0]  pol;
  logic [15:0] cdiv, dlen;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;

  logic        busy;
  logic [4:0]  ph;
  logic [15:0] dcnt, half;
  logic [7:0]  tsh, rsh;

  logic wr_ctrl, wr_fifo, rd_fifo, clr_tx, clr_rx;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic tick, load, din, done, rxr, cs_on;
  logic unused_bits;

  assign wr_ctrl = bus_en && bus_we && bus_addr[3:2] == 2'd0;
  assign wr_fifo = bus_en && bus_we && bus_addr[3:2] == 2'd1;
  assign rd_fifo = bus_en && !bus_we && bus_addr[3:2] == 2'd1;
  assign clr_tx  = wr_ctrl && bus_wdata[4];
  assign clr_rx  = wr_ctrl && bus_wdata[5];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:24], bus_wdata[20:16]};

  assign half = (cdiv[15:1] == 15'd0) ? 16'h8000 : {1'b0, cdiv[15:1]};
  assign tick = busy && (dcnt == half - 16'd1);
  assign load = ta && tx_cnt != '0 && (!busy || (tick && ph == 5'd17));
  assign din  = ren ? dq_i : miso_i;

  assign tx_push = wr_fifo && tx_cnt != FULL;
  assign tx_pop  = load;
  assign rx_push = tick && ph == 5'd15 && rx_cnt != FULL;
  assign rx_pop  = rd_fifo && rx_cnt != '0;

  assign done  = ta && tx_cnt == '0 && !busy;
  assign rxr   = rx_cnt >= RXR_LVL;
  assign irq_o = (intd && done) || (intr && rxr);

  assign sclk_o  = cpol ^ (busy && ph < 5'd16 && (ph[0] ^ cpha));
  assign mosi_o  = tsh[7];
  assign mosi_oe = !ren;
  assign cs_on   = (ta || busy) && gpol && csel != 2'd3;

  always_comb
    for (int i = 0; i < 3; i++)
      cs_o[i] = (cs_on && csel == 2'(i)) ? pol[i] : !pol[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {csel, cpha, cpol, gpol, ta, intd, intr, ren, pol} <= '0;
      cdiv <= '0;
      dlen <= '0;
    end else begin
      if (wr_ctrl) begin
        csel <= bus_wdata[1:0];
        cpha <= bus_wdata[2];
        cpol <= bus_wdata[3];
        gpol <= bus_wdata[6];
        ta   <= bus_wdata[7];
        intd <= bus_wdata[9];
        intr <= bus_wdata[10];
        ren  <= bus_wdata[12];
        pol  <= bus_wdata[23:21];
      end
      if (bus_en && bus_we && bus_addr[3:2] == 2'd2) cdiv <= bus_wdata[15:0];
      if (bus_en && bus_we && bus_addr[3:2] == 2'd3) dlen <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rsh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_pop);
    end
    if (!rst_n || clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= '0; dcnt <= '0; tsh <= '0; rsh <= '0;
    end else if (load) begin
      busy <= 1'b1; ph <= '0; dcnt <= '0; tsh <= tx_mem[tx_rp];
    end else if (busy) begin
      if (tick) begin
        dcnt <= '0;
        if (ph == 5'd17) begin
          busy <= 1'b0;
          ph   <= '0;
        end else begin
          ph <= ph + 5'd1;
        end
        if (ph < 5'd16 && !ph[0]) rsh <= {rsh[6:0], din};
        if (ph < 5'd16 && ph[0])  tsh <= {tsh[6:0], 1'b0};
      end else begin
        dcnt <= dcnt + 16'd1;
      end
    end
  end

  always_comb
    case (bus_addr[3:2])
      2'd0: bus_rdata = {8'b0, pol, rx_cnt == FULL, rxr, tx_cnt != FULL, rx_cnt != '0, done,
                         3'b0, ren, 1'b0, intr, intd, 1'b0, ta, gpol, 2'b0, cpol, cpha, csel};
      2'd1: bus_rdata = {24'b0, rx_mem[rx_rp]};
      2'd2: bus_rdata = {16'b0, cdiv};
      default: bus_rdata = {16'b0, dlen};
    endcase

  a_r5_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ta) && tx_cnt == '0 && !busy && intd |-> irq_o);
  a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ph >= 5'd16 |-> sclk_o == cpol);
  a_r7_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ ~pol));
  a_r10_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == FULL && !tx_pop && !clr_tx |=> tx_cnt == FULL);
  a_r4_rx_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_pop && !clr_rx |=> rx_cnt == $past(rx_cnt) + 1'b1);
  a_r11_start_needs_ta: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ta));
endmodule

// File: tb/spi_reg_master_tb.sv
module spi_reg_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk_o, mosi_o, mosi_oe, miso_i, dq_i, irq_o;
  logic [2:0] cs_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign miso_i = ~mosi_o;
  assign dq_i   = mosi_o;

  spi_reg_master u_dut (.clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .sclk_o, .mosi_o, .mosi_oe, .miso_i, .dq_i, .cs_o, .irq_o);

  // {cpol, cpha, ren, tx byte}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'hA5}, {3'b010, 8'h3C}, {3'b100, 8'h81}, {3'b110, 8'h7E},
    {3'b001, 8'hC3}, {3'b111, 8'h5A}, {3'b011, 8'h01}, {3'b100, 8'hFE}};

  logic mon_rst = 1'b1, mon_pol = 1'b0, mon_pha = 1'b0, prev_sclk, seen_rise, hi_done;
  logic [7:0] mon_byte;
  int since_rise, min_iv, max_iv, hi_len, hi_cnt;

  always @(negedge clk) begin
    if (mon_rst) begin
      mon_byte <= '0; seen_rise <= 1'b0; hi_done <= 1'b0; min_iv <= 1 << 30; max_iv <= 0;
      since_rise <= 0; hi_cnt <= 0; hi_len <= 0; prev_sclk <= sclk_o;
    end else begin
      prev_sclk <= sclk_o;
      since_rise <= since_rise + 1;
      hi_cnt <= hi_cnt + 1;
      if (sclk_o !== prev_sclk && sclk_o === (mon_pol ^ !mon_pha)) mon_byte <= {mon_byte[6:0], mosi_o};
      if (sclk_o && !prev_sclk) begin
        since_rise <= 1; hi_cnt <= 1; seen_rise <= 1'b1;
        if (seen_rise) begin
          if (since_rise < min_iv) min_iv <= since_rise;
          if (since_rise > max_iv) max_iv <= since_rise;
        end
      end
      if (!sclk_o && prev_sclk && seen_rise && !hi_done) begin hi_len <= hi_cnt; hi_done <= 1'b1; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(input logic ta, gp, cpol, cpha, ren, intd, intr,
                                     input logic [1:0] cs, input logic [2:0] pl, input logic clr);
    return {8'b0, pl, 8'b0, ren, 1'b0, intr, intd, 1'b0, ta, gp, clr, clr, cpol, cpha, cs};
  endfunction

  task automatic wait_done();
    logic [31:0] s;
    for (int n = 0; n < 5000; n++) begin
      rd(4'h0, s);
      if (s[16]) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, d); chk("R1 reset status", d, 32'h0004_0000);
    rd(4'h8, d); chk("R1 reset divider", d, 32'h0);
    chk("R1 reset cs idle", {29'b0, cs_o}, 32'h7);
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);

    wr(4'h0, cw(1, 1, 0, 0, 0, 1, 0, 2'd0, 3'b000, 0));
    rd(4'h0, d); chk("R5 done at once", {31'b0, d[16]}, 32'h1);
    chk("R5 irq on done", {31'b0, irq_o}, 32'h1);
    chk("R7 cs0 asserted", {29'b0, cs_o}, 32'h6);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd3, 3'b000, 0));
    chk("R7 code 3 none", {29'b0, cs_o}, 32'h7);
    wr(4'h0, cw(1, 0, 0, 0, 0, 0, 0, 2'd1, 3'b000, 0));
    chk("R7 global off", {29'b0, cs_o}, 32'h7);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd2, 3'b000, 0));
    chk("R7 cs2 asserted", {29'b0, cs_o}, 32'h3);
    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd1, 3'b010, 0));
    chk("R7 pol1 inactive low", {29'b0, cs_o}, 32'h5);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd1, 3'b010, 0));
    chk("R7 pol1 active high", {29'b0, cs_o}, 32'h7);

    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 0));
    wr(4'h4, 32'h11); wr(4'h4, 32'h22); wr(4'h4, 32'h33);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 1));
    rd(4'h0, d); chk("R6 clear bits read 0, tx emptied", d, 32'h0005_00C0);

    wr(4'h8, 32'd2);
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      logic [7:0] exp_rx;
      v = VEC[i];
      exp_rx = v[8] ? v[7:0] : ~v[7:0];
      mon_pol = v[10]; mon_pha = v[9];
      wr(4'h0, cw(0, 1, v[10], v[9], v[8], 0, 0, 2'd0, 3'b000, 1));
      mon_rst = 1'b1; @(negedge clk); mon_rst = 1'b0;
      wr(4'h4, {24'b0, v[7:0]});
      wr(4'h0, cw(1, 1, v[10], v[9], v[8], 0, 0, 2'd0, 3'b000, 0));
      chk("R8 output enable", {31'b0, mosi_oe}, {31'b0, !v[8]});
      wait_done();
      chk("R4 mosi MSB first", {24'b0, mon_byte}, {24'b0, v[7:0]});
      rd(4'h4, d); chk("R4 R8 rx byte", d, {24'b0, exp_rx});
      chk("R3 idle level", {31'b0, sclk_o}, {31'b0, v[10]});
    end
    mon_pol = 1'b0; mon_pha = 1'b0;

    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 1, 2'd0, 3'b000, 1));
    for (int i = 0; i < 17; i++) wr(4'h4, 32'h30 + i);
    rd(4'h0, d); chk("R9 R10 tx full flag", {31'b0, d[18]}, 32'h0);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 1, 2'd0, 3'b000, 0));
    wait_done();
    rd(4'h0, d); chk("R9 flags full rx", {27'b0, d[20:16]}, 32'h1F);
    chk("R9 irq on rx level", {31'b0, irq_o}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(4'h4, d); chk("R10 rx order, 17th dropped", d, {24'b0, ~(8'h30 + 8'(i))});
      if (i == 3) begin rd(4'h0, d); chk("R9 level at 12", {31'b0, d[19]}, 32'h1); end
      if (i == 4) begin
        rd(4'h0, d); chk("R9 level at 11", {31'b0, d[19]}, 32'h0);
        chk("R9 irq drops", {31'b0, irq_o}, 32'h0);
      end
    end
    rd(4'h0, d); chk("R9 rx empty", {31'b0, d[17]}, 32'h0);
    rd(4'h4, d);
    wr(4'h4, 32'hA5);
    wait_done();
    rd(4'h4, d); chk("R10 empty read harmless", d, 32'h5A);

    wr(4'h8, 32'd7);
    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 1));
    mon_rst = 1'b1; @(negedge clk); mon_rst = 1'b0;
    wr(4'h4, 32'h0F); wr(4'h4, 32'hF0);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 0));
    wait_done();
    chk("R2 odd divisor rounds to 6", min_iv, 6);
    chk("R3 idle clock at byte gap", max_iv, 12);

    wr(4'h8, 32'd8);
    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 1));
    wr(4'h4, 32'h11); wr(4'h4, 32'h22);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 0));
    repeat (20) @(negedge clk);
    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 0));
    chk("R11 cs held mid-byte", {29'b0, cs_o}, 32'h6);
    repeat (120) @(negedge clk);
    chk("R11 cs released", {29'b0, cs_o}, 32'h7);
    rd(4'h4, d); chk("R11 byte completed", d, 32'hEE);
    rd(4'h0, d); chk("R11 no second byte", {31'b0, d[17]}, 32'h0);

    wr(4'hC, 32'h1234_ABCD);
    rd(4'hC, d); chk("R12 length register", d, 32'h0000_ABCD);

    wr(4'h8, 32'd0);
    wr(4'h0, cw(0, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 1));
    mon_rst = 1'b1; @(negedge clk); mon_rst = 1'b0;
    wr(4'h4, 32'h80);
    wr(4'h0, cw(1, 1, 0, 0, 0, 0, 0, 2'd0, 3'b000, 0));
    for (int n = 0; n < 70000 && !hi_done; n++) @(negedge clk);
    chk("R2 zero divider half period", hi_len, 32768);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule